// File: doc/BRIEF.md
# Pipelined Color Palette Lookup

This block is the digital core in front of a triple video converter. On every pixel clock it takes an 8-bit color index and a blank flag, qualifies the index with a programmable read mask, looks the result up in a 256-entry table, and drives three 6-bit codes (red, green, blue) to the external converters. Each entry holds one 18-bit color, so 256 colors can be on screen at once out of 262,144. The index, the mask, the lookup and the output each have their own register stage, so a pixel reaches the outputs a fixed four clocks after it is sampled. Blanking travels through the same stages and clears all three channels together.

A separate host port, with two select lines, active-low read and write strobes and an 8-bit data bus, loads and reads the table and the mask while pixels keep flowing. The strobes are brought into the pixel clock domain through two-flop synchronizers with edge detection. A color moves as three 6-bit transfers, red first and blue last. The table entry is written in a single cycle, only after the blue transfer, so the pixel path never sees a color that is half old and half new.

Top module: `palette_lookup`

## Requirements
- R1: An index applied before rising edge n appears as `{red_code, grn_code, blu_code}` = table[index AND mask] right after rising edge n+3. That is four register stages, with no other latency.
- R2: Blank sampled with a pixel forces all three channel codes to 0 on the same cycle that pixel would have appeared, and does not affect neighbouring pixels.
- R3: The mask is ANDed bit by bit with the pixel index before lookup. It changes only through a host write with select 2'b10, and it reads back through select 2'b10.
- R4: Host select encoding: 2'b00 is the write address, 2'b01 is color data, 2'b10 is the pixel mask and 2'b11 is the read address. A read with a select returns that register on `host_rdata`.
- R5: Color data writes are taken in the order red, green, blue. After blue the entry is stored at the write address, and the write address increments, wrapping from 255 to 0.
- R6: A table entry changes in one step at the blue transfer, so a pixel reading it during an update shows either the complete old color or the complete new one.
- R7: Color data reads return red, green, blue in turn on bits [5:0], with bits [7:6] reading 0. The read address increments after the blue read, wrapping from 255 to 0.
- R8: `host_oe` is high exactly while `host_rd_n` is low. This is how the tri-state bus driver is enabled.
- R9: Writing the write address (or the read address) restarts that direction's component sequence at red.
- R10: After reset the channel codes are 0, both addresses are 0, the mask reads 8'hFF and `host_oe` is 0.
- R11: Each low pulse of a strobe acts exactly once, however many clocks it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_idx | input | 8 | Pixel color index |
| pix_blank | input | 1 | Blank request for this pixel |
| red_code | output | 6 | Red channel code |
| grn_code | output | 6 | Green channel code |
| blu_code | output | 6 | Blue channel code |
| hsel | input | 2 | Host register select |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_oe is high |
| host_oe | output | 1 | Drive enable for the host data bus |

## Verification
The hardest case to reach is a host update landing on the very entry that the pixel stream is reading. To get there, the bench holds the pixel index fixed on one entry and keeps the pipeline full, then loads a new color into that entry whose three fields all differ from the old ones. Every output in between must equal one of the two complete colors. A long write strobe on a color transfer, followed by readback of the entry and the write address, shows that the strobe acted only once.

// File: rtl/plt_pkg.sv
package plt_pkg;
  typedef enum logic [1:0] {
    SEL_WADDR = 2'b00,
    SEL_DATA  = 2'b01,
    SEL_MASK  = 2'b10,
    SEL_RADDR = 2'b11
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } comp_ph_e;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int N           = 1,
  parameter bit DETECT_RISE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] edge_pulse
);
  logic [N-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      last_q <= '1;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    if (DETECT_RISE) begin : g_rise
      assign edge_pulse[i] = sync_q[i] & ~last_q[i];
    end else begin : g_fall
      assign edge_pulse[i] = ~sync_q[i] & last_q[i];
    end
  end
endmodule

// File: rtl/palette_mem.sv
module palette_mem #(
  parameter int IDX_W = 8,
  parameter int CW    = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [3*CW-1:0]   wdata,
  input  logic [IDX_W-1:0]  pix_raddr,
  output logic [3*CW-1:0]   pix_rdata,
  input  logic [IDX_W-1:0]  host_raddr,
  output logic [3*CW-1:0]   host_rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int EW    = 3 * CW;

  logic [EW-1:0] tbl [DEPTH];

  always_ff @(posedge clk) begin
    if (we) tbl[waddr] <= wdata;
  end

  assign pix_rdata  = tbl[pix_raddr];
  assign host_rdata = tbl[host_raddr];
endmodule

// File: rtl/host_regs.sv
module host_regs
  import plt_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              rd_done,
  input  logic [1:0]        sel,
  input  logic [IDX_W-1:0]  wdata,
  input  logic [3*CW-1:0]   rd_entry,
  output logic [IDX_W-1:0]  mask,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [IDX_W-1:0]  rd_addr,
  output logic [1:0]        wr_phase,
  output logic              mem_we,
  output logic [3*CW-1:0]   mem_wdata,
  output logic [IDX_W-1:0]  rdata
);
  localparam int EW  = 3 * CW;
  localparam int PAD = IDX_W - CW;

  host_sel_e        sel_e;
  logic [IDX_W-1:0] mask_q, mask_d;
  logic [IDX_W-1:0] waddr_q, waddr_d;
  logic [IDX_W-1:0] raddr_q, raddr_d;
  comp_ph_e         wph_q, wph_d;
  comp_ph_e         rph_q, rph_d;
  logic [CW-1:0]    stg_r_q, stg_r_d;
  logic [CW-1:0]    stg_g_q, stg_g_d;
  logic             upd_en;
  logic [CW-1:0]    rd_comp;

  assign sel_e = host_sel_e'(sel);

  always_comb begin
    mask_d    = mask_q;
    waddr_d   = waddr_q;
    raddr_d   = raddr_q;
    wph_d     = wph_q;
    rph_d     = rph_q;
    stg_r_d   = stg_r_q;
    stg_g_d   = stg_g_q;
    mem_we    = 1'b0;
    mem_wdata = {stg_r_q, stg_g_q, wdata[CW-1:0]};

    if (rd_done && sel_e == SEL_DATA) begin
      case (rph_q)
        PH_RED:  rph_d = PH_GRN;
        PH_GRN:  rph_d = PH_BLU;
        default: begin
          rph_d   = PH_RED;
          raddr_d = raddr_q + 1'b1;
        end
      endcase
    end

    if (wr_fire) begin
      case (sel_e)
        SEL_WADDR: begin
          waddr_d = wdata;
          wph_d   = PH_RED;
        end
        SEL_DATA: begin
          case (wph_q)
            PH_RED: begin
              stg_r_d = wdata[CW-1:0];
              wph_d   = PH_GRN;
            end
            PH_GRN: begin
              stg_g_d = wdata[CW-1:0];
              wph_d   = PH_BLU;
            end
            default: begin
              mem_we  = 1'b1;
              waddr_d = waddr_q + 1'b1;
              wph_d   = PH_RED;
            end
          endcase
        end
        SEL_MASK: mask_d = wdata;
        default: begin
          raddr_d = wdata;
          rph_d   = PH_RED;
        end
      endcase
    end
  end

  assign upd_en = wr_fire | rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      waddr_q <= '0;
      raddr_q <= '0;
      wph_q   <= PH_RED;
      rph_q   <= PH_RED;
      stg_r_q <= '0;
      stg_g_q <= '0;
    end else if (upd_en) begin
      mask_q  <= mask_d;
      waddr_q <= waddr_d;
      raddr_q <= raddr_d;
      wph_q   <= wph_d;
      rph_q   <= rph_d;
      stg_r_q <= stg_r_d;
      stg_g_q <= stg_g_d;
    end
  end

  always_comb begin
    case (rph_q)
      PH_RED:  rd_comp = rd_entry[EW-1 -: CW];
      PH_GRN:  rd_comp = rd_entry[EW-CW-1 -: CW];
      default: rd_comp = rd_entry[CW-1:0];
    endcase
  end

  always_comb begin
    case (sel_e)
      SEL_WADDR: rdata = waddr_q;
      SEL_DATA:  rdata = {{PAD{1'b0}}, rd_comp};
      SEL_MASK:  rdata = mask_q;
      default:   rdata = raddr_q;
    endcase
  end

  assign mask     = mask_q;
  assign wr_addr  = waddr_q;
  assign rd_addr  = raddr_q;
  assign wr_phase = wph_q;
endmodule

// File: rtl/pixel_pipe.sv
module pixel_pipe #(
  parameter int IDX_W = 8,
  parameter int CW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              blank,
  input  logic [IDX_W-1:0]  mask,
  output logic [IDX_W-1:0]  lut_addr,
  input  logic [3*CW-1:0]   lut_data,
  output logic [CW-1:0]     chan [3]
);
  localparam int EW    = 3 * CW;
  localparam int NCHAN = 3;

  logic [IDX_W-1:0] s1_idx_q, s2_addr_q;
  logic             s1_blank_q, s2_blank_q, s3_blank_q;
  logic [EW-1:0]    s3_col_q;
  logic [CW-1:0]    out_q [NCHAN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_idx_q   <= '0;
      s1_blank_q <= 1'b1;
      s2_addr_q  <= '0;
      s2_blank_q <= 1'b1;
      s3_col_q   <= '0;
      s3_blank_q <= 1'b1;
    end else begin
      s1_idx_q   <= idx;
      s1_blank_q <= blank;
      s2_addr_q  <= s1_idx_q & mask;
      s2_blank_q <= s1_blank_q;
      s3_col_q   <= lut_data;
      s3_blank_q <= s2_blank_q;
    end
  end

  assign lut_addr = s2_addr_q;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic [CW-1:0] out_d;
    assign out_d = s3_blank_q ? '0 : s3_col_q[EW-1-c*CW -: CW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[c] <= '0;
      else        out_q[c] <= out_d;
    end

    assign chan[c] = out_q[c];
  end
endmodule

// File: rtl/palette_lookup.sv
module palette_lookup
  import plt_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              pix_blank,
  output logic [CW-1:0]     red_code,
  output logic [CW-1:0]     grn_code,
  output logic [CW-1:0]     blu_code,
  input  logic [1:0]        hsel,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [IDX_W-1:0]  host_wdata,
  output logic [IDX_W-1:0]  host_rdata,
  output logic              host_oe
);
  localparam int EW = 3 * CW;

  logic             rst_meta_q, rst_sync_n;
  logic             wr_fire, rd_done;
  logic [IDX_W-1:0] mask_q, wr_addr_q, rd_addr_q, lut_addr;
  logic [1:0]       wr_phase;
  logic             mem_we;
  logic [EW-1:0]    mem_wdata, lut_data, host_entry;
  logic [CW-1:0]    chan [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  host_sync #(.N(1), .DETECT_RISE(1'b0)) u_wr_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_in(host_wr_n), .edge_pulse(wr_fire)
  );

  host_sync #(.N(1), .DETECT_RISE(1'b1)) u_rd_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_in(host_rd_n), .edge_pulse(rd_done)
  );

  host_regs #(.IDX_W(IDX_W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_fire(wr_fire), .rd_done(rd_done),
    .sel(hsel), .wdata(host_wdata), .rd_entry(host_entry),
    .mask(mask_q), .wr_addr(wr_addr_q), .rd_addr(rd_addr_q),
    .wr_phase(wr_phase), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .rdata(host_rdata)
  );

  palette_mem #(.IDX_W(IDX_W), .CW(CW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(wr_addr_q), .wdata(mem_wdata),
    .pix_raddr(lut_addr), .pix_rdata(lut_data),
    .host_raddr(rd_addr_q), .host_rdata(host_entry)
  );

  pixel_pipe #(.IDX_W(IDX_W), .CW(CW)) u_pipe (
    .clk(clk), .rst_n(rst_sync_n), .idx(pix_idx), .blank(pix_blank),
    .mask(mask_q), .lut_addr(lut_addr), .lut_data(lut_data), .chan(chan)
  );

  assign red_code = chan[0];
  assign grn_code = chan[1];
  assign blu_code = chan[2];
  assign host_oe  = ~host_rd_n;
endmodule

// File: rtl/palette_lookup_chk.sv
module palette_lookup_chk #(
  parameter int IDX_W = 8,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_blank,
  input logic [CW-1:0]    red_code,
  input logic [CW-1:0]    grn_code,
  input logic [CW-1:0]    blu_code,
  input logic [1:0]       hsel,
  input logic             host_rd_n,
  input logic             host_oe,
  input logic [IDX_W-1:0] host_rdata,
  input logic             wr_fire,
  input logic             mem_we,
  input logic [IDX_W-1:0] mask_q,
  input logic [IDX_W-1:0] wr_addr_q
);
  logic [3:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 4'hF)  cyc_q <= cyc_q + 4'd1;
  end

  p_blank_all_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 4'd5 && $past(pix_blank, 4)) |->
      (red_code == '0 && grn_code == '0 && blu_code == '0));

  p_bus_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rd_n) |-> !host_oe);

  p_color_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_oe && hsel == 2'b01) |-> host_rdata[IDX_W-1:CW] == '0);

  p_mask_by_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 4'd3 && !$stable(mask_q)) |-> $past(wr_fire && hsel == 2'b10));

  p_commit_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_fire && hsel == 2'b01));

  p_waddr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 4'd3 && !$stable(wr_addr_q) && !$past(wr_fire && hsel == 2'b00)) |->
      wr_addr_q == IDX_W'($past(wr_addr_q) + 1'b1));
endmodule

bind palette_lookup palette_lookup_chk #(.IDX_W(IDX_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_blank(pix_blank),
  .red_code(red_code), .grn_code(grn_code), .blu_code(blu_code),
  .hsel(hsel), .host_rd_n(host_rd_n), .host_oe(host_oe),
  .host_rdata(host_rdata), .wr_fire(wr_fire), .mem_we(mem_we),
  .mask_q(mask_q), .wr_addr_q(wr_addr_q)
);

// File: tb/sim_palette_lookup.sv
module sim_palette_lookup;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pix_idx;
  logic       pix_blank;
  logic [5:0] red_code, grn_code, blu_code;
  logic [1:0] hsel;
  logic       host_rd_n, host_wr_n;
  logic [7:0] host_wdata, host_rdata;
  logic       host_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [17:0] model [256];

  palette_lookup u0 (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .pix_blank(pix_blank),
    .red_code(red_code), .grn_code(grn_code), .blu_code(blu_code),
    .hsel(hsel), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_oe(host_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] color_of(input int i);
    logic [5:0] r, g, b;
    r = 6'((i * 7 + 1) % 64);
    g = 6'((i * 13 + 5) % 64);
    b = 6'((i ^ 8'h5A) % 64);
    return {r, g, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] s, input logic [7:0] d, input int hold);
    @(negedge clk);
    hsel = s; host_wdata = d; host_wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    hsel = s; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = host_rdata;
    chk(host_oe == 1'b1, "R8 oe during read", int'(host_oe), 1);
    host_rd_n = 1'b1;
    #1;
    chk(host_oe == 1'b0, "R8 oe after read", int'(host_oe), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic write_entry(input int i, input logic [17:0] c);
    host_wr(2'b01, {2'b00, c[17:12]}, 4);
    host_wr(2'b01, {2'b00, c[11:6]}, 4);
    host_wr(2'b01, {2'b00, c[5:0]}, 4);
    model[i] = c;
  endtask

  task automatic read_entry(input int i, input string tag);
    logic [7:0] d;
    logic [17:0] e;
    e = model[i];
    host_rd(2'b01, d); chk(d == {2'b00, e[17:12]}, tag, d, {2'b00, e[17:12]});
    host_rd(2'b01, d); chk(d == {2'b00, e[11:6]},  tag, d, {2'b00, e[11:6]});
    host_rd(2'b01, d); chk(d == {2'b00, e[5:0]},   tag, d, {2'b00, e[5:0]});
  endtask

  // Pixel sweep: expected value leaves the bench pipe four negedges after drive (R1, R2)
  task automatic sweep(input logic [7:0] m, input int blank_mod);
    logic [17:0] hist [4];
    logic        hb   [4];
    for (int n = 0; n < 260; n++) begin
      @(negedge clk);
      if (n >= 4) begin
        chk({red_code, grn_code, blu_code} == hist[3],
            hb[3] ? "R2 blank all channels" : "R1 masked lookup",
            {red_code, grn_code, blu_code}, hist[3]);
      end
      for (int k = 3; k > 0; k--) begin
        hist[k] = hist[k-1];
        hb[k]   = hb[k-1];
      end
      pix_idx   = 8'(n);
      pix_blank = (blank_mod != 0) && (n % blank_mod == 1);
      hb[0]     = pix_blank;
      hist[0]   = pix_blank ? 18'd0 : model[pix_idx & m];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [17:0] oldc, newc;
    rst_n = 1'b0; pix_idx = '0; pix_blank = 1'b0; hsel = '0;
    host_rd_n = 1'b1; host_wr_n = 1'b1; host_wdata = '0;
    repeat (3) @(negedge clk);
    chk({red_code, grn_code, blu_code} == 18'd0, "R10 outputs in reset",
        {red_code, grn_code, blu_code}, 0);
    chk(host_oe == 1'b0, "R10 oe in reset", int'(host_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    host_rd(2'b10, d); chk(d == 8'hFF, "R10 R3 mask reset", d, 8'hFF);
    host_rd(2'b00, d); chk(d == 8'h00, "R10 R4 write address reset", d, 0);
    host_rd(2'b11, d); chk(d == 8'h00, "R10 R4 read address reset", d, 0);

    // Load the whole table (R5)
    host_wr(2'b00, 8'h00, 4);
    for (int i = 0; i < 256; i++) write_entry(i, color_of(i));
    host_rd(2'b00, d); chk(d == 8'h00, "R5 write address wrap", d, 0);

    // Read back the whole table (R7)
    host_wr(2'b11, 8'h00, 4);
    for (int i = 0; i < 256; i++) read_entry(i, "R7 color readback");
    host_rd(2'b11, d); chk(d == 8'h00, "R7 read address wrap", d, 0);

    // Pixel path sweeps under several masks and blank patterns (R1, R2, R3)
    sweep(8'hFF, 0);
    host_wr(2'b10, 8'h0F, 4);
    host_rd(2'b10, d); chk(d == 8'h0F, "R3 R4 mask readback", d, 8'h0F);
    sweep(8'h0F, 3);
    host_wr(2'b10, 8'hA5, 4);
    sweep(8'hA5, 5);
    host_wr(2'b10, 8'hFF, 4);

    // R9: abandoned partial write, then address reload restarts at red
    host_wr(2'b00, 8'd5, 4);
    host_wr(2'b01, 8'h3F, 4);
    host_wr(2'b00, 8'd7, 4);
    write_entry(7, 18'h2A5C3);
    host_rd(2'b00, d); chk(d == 8'd8, "R9 write address after reload", d, 8);
    host_wr(2'b11, 8'd5, 4);
    read_entry(5, "R9 entry untouched");
    host_rd(2'b01, d);
    host_wr(2'b11, 8'd7, 4);
    read_entry(7, "R9 entry after reload");

    // R11: long strobe on a color transfer acts once
    host_wr(2'b00, 8'd9, 4);
    host_wr(2'b01, 8'h11, 25);
    host_wr(2'b01, 8'h22, 4);
    host_wr(2'b01, 8'h33, 4);
    model[9] = {6'h11, 6'h22, 6'h33};
    host_rd(2'b00, d); chk(d == 8'd10, "R11 single action per strobe", d, 10);
    host_wr(2'b11, 8'd9, 4);
    read_entry(9, "R11 entry after long strobe");

    // R6: update the entry being displayed
    oldc = model[8'h33];
    newc = ~oldc;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); pix_idx = 8'h33; pix_blank = 1'b0;
    end
    fork
      begin
        for (int k = 0; k < 90; k++) begin
          @(negedge clk);
          chk({red_code, grn_code, blu_code} == oldc ||
              {red_code, grn_code, blu_code} == newc,
              "R6 no partial color", {red_code, grn_code, blu_code}, newc);
        end
      end
      begin
        host_wr(2'b00, 8'h33, 4);
        write_entry(8'h33, newc);
      end
    join
    chk({red_code, grn_code, blu_code} == newc, "R6 new color shown",
        {red_code, grn_code, blu_code}, newc);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule